// File: doc/BRIEF.md
# Inter-Processor Byte Mailbox

This block lets one processor hand single bytes to another through a one-byte holding register. A full/empty flip-flop sits beside the register and paces the transfer. The sending processor stores a byte through its own small register port, and that store marks the mailbox full. The receiving processor takes the byte through a second port, and that take marks the mailbox empty, which frees the sender to store the next byte.

Each side can poll the full flag. Each side can also be told about it without polling, in one of two ways:

- Each side has an interrupt line with its own enable and its own choice of level or one-cycle pulse signalling. The receiver's line tracks "full" and the sender's line tracks "empty".
- Two direct-memory-access request lines, one per side, follow the flag and its inverse. A DMA engine on each side can then move whole blocks one byte at a time.

Misuse is recorded in two sticky flags, which stay set until software clears them. A store while the mailbox is full is dropped and flagged as an overrun. A take while it is empty is flagged as an underrun.

Each port decodes a two-bit register address:

| Address | Register | Sender port | Receiver port |
|---|---|---|---|
| 0 | Data | write stores a byte; reads return 0 | read takes the byte; writes are ignored |
| 1 | Status | read and write-one-to-clear | read and write-one-to-clear |
| 2 | Control | read/write | read/write |
| 3 | none | reads return 0 | reads return 0 |

Read data is combinational from the port address. Writes, and the clearing effect of a receiver data read, take effect at the rising clock edge.

Top module: `ipc_byte_mailbox`

## Requirements
- R1: After reset the following hold: the full flag is 0; the sender DMA request is 1 and the receiver DMA request is 0; both interrupt lines are 0; both sticky flags are 0; both control registers read 0.
- R2: A sender write to address 0 while the mailbox is empty stores the byte and sets the full flag at that clock edge.
- R3: A receiver read of address 0 while the mailbox is full returns the stored byte in the same cycle and clears the full flag at that clock edge.
- R4: The status word at address 1 reads the same on both ports. Bit 0 is the full flag, bit 1 is overrun and bit 2 is underrun; all other bits are 0.
- R5: A sender write to address 0 while the mailbox is full is dropped: the stored byte and the full flag are unchanged. The same edge sets overrun. Overrun stays set until the sender writes address 1 with bit 1 = 1.
- R6: A receiver read of address 0 while the mailbox is empty returns the last stored byte and leaves the full flag at 0. The same edge sets underrun. Underrun stays set until the receiver writes address 1 with bit 2 = 1.
- R7: Control register, address 2, one per side. Bit 0 is the interrupt enable and bit 1 selects pulse mode (1) or level mode (0). In level mode the receiver interrupt equals enable AND full.
- R8: In pulse mode the receiver interrupt is high for exactly the one cycle after the edge at which the full flag rises.
- R9: The sender interrupt behaves like the receiver interrupt but tracks "empty". In level mode it equals enable AND NOT full. In pulse mode it is high for exactly the one cycle after the edge at which the full flag falls.
- R10: The receiver DMA request equals the full flag at all times. The sender DMA request equals its inverse.
- R11: With the enable bit at 0, an interrupt line stays 0 whatever the flag and its transitions do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_cs | input | 1 | Sender port access strobe |
| tx_we | input | 1 | Sender port write (1) or read (0) |
| tx_addr | input | 2 | Sender port register address |
| tx_wdata | input | DATA_W | Sender port write data |
| tx_rdata | output | DATA_W | Sender port read data, combinational |
| rx_cs | input | 1 | Receiver port access strobe |
| rx_we | input | 1 | Receiver port write (1) or read (0) |
| rx_addr | input | 2 | Receiver port register address |
| rx_wdata | input | DATA_W | Receiver port write data |
| rx_rdata | output | DATA_W | Receiver port read data, combinational |
| tx_irq | output | 1 | Sender interrupt (empty) |
| rx_irq | output | 1 | Receiver interrupt (full) |
| tx_dma_req | output | 1 | Sender DMA request (mailbox empty) |
| rx_dma_req | output | 1 | Receiver DMA request (mailbox full) |

## Verification
The hardest situation to reach from the ports is a single-cycle interrupt pulse that coincides with other activity on the same edge. One example is a sender store and a receiver take landing on the same clock edge while the mailbox is full. The other is an overrun store landing on the edge that drains the mailbox. The bench drives both ports inside one low clock phase so that the two accesses meet at one edge. It then samples the interrupt lines in the cycle after that edge and again one cycle later, which confirms that each pulse lasts exactly one cycle and that the dropped store neither refills the mailbox nor fires the receiver pulse.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int MB_ADDR_W = 2;

  typedef enum logic [MB_ADDR_W-1:0] {
    MB_REG_DATA   = 2'd0,
    MB_REG_STATUS = 2'd1,
    MB_REG_CTRL   = 2'd2,
    MB_REG_SPARE  = 2'd3
  } mb_reg_e;

  localparam int ST_FULL_BIT   = 0;
  localparam int ST_OVR_BIT    = 1;
  localparam int ST_UDR_BIT    = 2;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_EDGE_BIT = 1;

  // Interrupt output selection: level or one-cycle pulse, gated by enable.
  function automatic logic irq_select(logic en, logic edge_mode,
                                      logic pulse, logic level);
    return en & (edge_mode ? pulse : level);
  endfunction
endpackage

// File: rtl/mb_bus_decode.sv
module mb_bus_decode
  import mb_pkg::*;
(
  input  logic                 cs,
  input  logic                 we,
  input  logic [MB_ADDR_W-1:0] addr,
  output logic                 wr_data,
  output logic                 wr_status,
  output logic                 wr_ctrl,
  output logic                 rd_data
);
  mb_reg_e sel;
  assign sel = mb_reg_e'(addr);

  always_comb begin
    wr_data   = 1'b0;
    wr_status = 1'b0;
    wr_ctrl   = 1'b0;
    rd_data   = 1'b0;
    if (cs) begin
      unique case (sel)
        MB_REG_DATA:   begin wr_data = we; rd_data = ~we; end
        MB_REG_STATUS: wr_status = we;
        MB_REG_CTRL:   wr_ctrl   = we;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/mb_holding_reg.sv
module mb_holding_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [DATA_W-1:0] din,
  input  logic              pop_req,
  input  logic              ovr_clr,
  input  logic              udr_clr,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              overrun,
  output logic              underrun,
  output logic              evt_fill,
  output logic              evt_drain
);
  logic evt_ovr;
  logic evt_udr;

  // Accepted and refused accesses, judged against the flag before the edge.
  assign evt_fill  = load_req & ~full;
  assign evt_ovr   = load_req &  full;
  assign evt_drain = pop_req  &  full;
  assign evt_udr   = pop_req  & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (evt_fill) begin
      dout <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
    end else if (evt_fill) begin
      full <= 1'b1;
    end else if (evt_drain) begin
      full <= 1'b0;
    end
  end

  // Sticky flags: a new event wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (evt_ovr)      overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
      if (evt_udr)      underrun <= 1'b1;
      else if (udr_clr) underrun <= 1'b0;
    end
  end

  AST_FILL_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |=> full); // R2
  AST_FILL_LOADS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |=> (dout == $past(din))); // R2
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drain |=> !full); // R3
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && full && !pop_req) |=> (full && $stable(dout))); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && full) |=> overrun); // R5
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !full && !load_req) |=> (underrun && !full && $stable(dout))); // R6
endmodule

// File: rtl/mb_side_irq.sv
module mb_side_irq
  import mb_pkg::*;
#(
  parameter int  DATA_W   = 8,
  parameter bit  ON_FULL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              full,
  input  logic              evt_fill,
  input  logic              evt_drain,
  output logic              ctrl_en,
  output logic              ctrl_edge,
  output logic              irq
);
  logic level_cond;
  logic evt_trigger;
  logic pulse_q;

  generate
    if (ON_FULL) begin : g_full_side
      assign level_cond  = full;
      assign evt_trigger = evt_fill;
    end else begin : g_empty_side
      assign level_cond  = ~full;
      assign evt_trigger = evt_drain;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_edge <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_en   <= ctrl_wdata[CTRL_EN_BIT];
      ctrl_edge <= ctrl_wdata[CTRL_EDGE_BIT];
    end
  end

  // Pulse register: high in the cycle right after the flag transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= evt_trigger;
  end

  assign irq = irq_select(ctrl_en, ctrl_edge, pulse_q, level_cond);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq); // R11
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_edge) |-> (irq == level_cond)); // R7
endmodule

// File: rtl/ipc_byte_mailbox.sv
module ipc_byte_mailbox
  import mb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_cs,
  input  logic                 tx_we,
  input  logic [MB_ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0]    tx_wdata,
  output logic [DATA_W-1:0]    tx_rdata,
  input  logic                 rx_cs,
  input  logic                 rx_we,
  input  logic [MB_ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0]    rx_wdata,
  output logic [DATA_W-1:0]    rx_rdata,
  output logic                 tx_irq,
  output logic                 rx_irq,
  output logic                 tx_dma_req,
  output logic                 rx_dma_req
);
  localparam int FLAG_BITS = 3;

  logic              tx_wr_data, tx_wr_status, tx_wr_ctrl, unused_tx_rd;
  logic              rx_wr_data_unused, rx_wr_status, rx_wr_ctrl, rx_rd_data;
  logic [DATA_W-1:0] held;
  logic              full, overrun, underrun, evt_fill, evt_drain;
  logic              tx_en, tx_edge, rx_en, rx_edge;
  logic [DATA_W-1:0] status_word;
  logic              unused_wdata;

  function automatic logic [DATA_W-1:0] pack_status(logic f, logic o, logic u);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ST_FULL_BIT] = f;
    w[ST_OVR_BIT]  = o;
    w[ST_UDR_BIT]  = u;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(logic en, logic edge_mode);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = en;
    w[CTRL_EDGE_BIT] = edge_mode;
    return w;
  endfunction

  mb_bus_decode u_tx_dec (
    .cs(tx_cs), .we(tx_we), .addr(tx_addr),
    .wr_data(tx_wr_data), .wr_status(tx_wr_status),
    .wr_ctrl(tx_wr_ctrl), .rd_data(unused_tx_rd)
  );

  mb_bus_decode u_rx_dec (
    .cs(rx_cs), .we(rx_we), .addr(rx_addr),
    .wr_data(rx_wr_data_unused), .wr_status(rx_wr_status),
    .wr_ctrl(rx_wr_ctrl), .rd_data(rx_rd_data)
  );

  mb_holding_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_req(tx_wr_data), .din(tx_wdata),
    .pop_req(rx_rd_data),
    .ovr_clr(tx_wr_status & tx_wdata[ST_OVR_BIT]),
    .udr_clr(rx_wr_status & rx_wdata[ST_UDR_BIT]),
    .dout(held), .full(full), .overrun(overrun), .underrun(underrun),
    .evt_fill(evt_fill), .evt_drain(evt_drain)
  );

  mb_side_irq #(.DATA_W(DATA_W), .ON_FULL(1'b0)) u_tx_irq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(tx_wr_ctrl), .ctrl_wdata(tx_wdata),
    .full(full), .evt_fill(evt_fill), .evt_drain(evt_drain),
    .ctrl_en(tx_en), .ctrl_edge(tx_edge), .irq(tx_irq)
  );

  mb_side_irq #(.DATA_W(DATA_W), .ON_FULL(1'b1)) u_rx_irq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(rx_wr_ctrl), .ctrl_wdata(rx_wdata),
    .full(full), .evt_fill(evt_fill), .evt_drain(evt_drain),
    .ctrl_en(rx_en), .ctrl_edge(rx_edge), .irq(rx_irq)
  );

  assign status_word = pack_status(full, overrun, underrun);

  always_comb begin
    unique case (mb_reg_e'(tx_addr))
      MB_REG_STATUS: tx_rdata = status_word;
      MB_REG_CTRL:   tx_rdata = pack_ctrl(tx_en, tx_edge);
      default:       tx_rdata = '0;
    endcase
  end

  always_comb begin
    unique case (mb_reg_e'(rx_addr))
      MB_REG_DATA:   rx_rdata = held;
      MB_REG_STATUS: rx_rdata = status_word;
      MB_REG_CTRL:   rx_rdata = pack_ctrl(rx_en, rx_edge);
      default:       rx_rdata = '0;
    endcase
  end

  assign rx_dma_req = full;
  assign tx_dma_req = ~full;

  assign unused_wdata = ^{rx_wdata[DATA_W-1:FLAG_BITS], rx_wdata[ST_OVR_BIT],
                          rx_wr_data_unused, unused_tx_rd,
                          tx_wdata[ST_UDR_BIT]};

  AST_DMA_FOLLOWS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |=> (rx_dma_req && !tx_dma_req)); // R10
  AST_DMA_FOLLOWS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drain |=> (tx_dma_req && !rx_dma_req)); // R10
  AST_RX_PULSE_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fill && rx_en && rx_edge && $stable(rx_en) && !rx_wr_ctrl) |=> rx_irq); // R8
  AST_TX_PULSE_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_drain && tx_en && tx_edge && !tx_wr_ctrl) |=> tx_irq); // R9
endmodule

// File: tb/tb_ipc_byte_mailbox.sv
module tb_ipc_byte_mailbox;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_cs = 0, tx_we = 0, rx_cs = 0, rx_we = 0;
  logic [1:0] tx_addr = 0, rx_addr = 0;
  logic [DATA_W-1:0] tx_wdata = 0, rx_wdata = 0;
  logic [DATA_W-1:0] tx_rdata, rx_rdata;
  logic tx_irq, rx_irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  ipc_byte_mailbox #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_cs(tx_cs), .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .tx_rdata(tx_rdata),
    .rx_cs(rx_cs), .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
    .rx_rdata(rx_rdata),
    .tx_irq(tx_irq), .rx_irq(rx_irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sender write: drive in low phase, commit at next rising edge.
  task automatic tx_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    tx_cs = 1; tx_we = 1; tx_addr = a; tx_wdata = d;
    @(posedge clk); #1;
    tx_cs = 0; tx_we = 0;
  endtask

  task automatic rx_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    rx_cs = 1; rx_we = 1; rx_addr = a; rx_wdata = d;
    @(posedge clk); #1;
    rx_cs = 0; rx_we = 0;
  endtask

  // Receiver data read with side effect at the edge.
  task automatic rx_pop(output logic [7:0] d);
    @(negedge clk);
    rx_cs = 1; rx_we = 0; rx_addr = 2'd0;
    #1 d = rx_rdata;
    @(posedge clk); #1;
    rx_cs = 0;
  endtask

  // Side-effect-free peeks (status/control), inside the low phase.
  task automatic tx_peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    tx_cs = 1; tx_we = 0; tx_addr = a;
    #1 d = tx_rdata;
    tx_cs = 0;
  endtask

  task automatic rx_peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rx_cs = 1; rx_we = 0; rx_addr = a;
    #1 d = rx_rdata;
    rx_cs = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    do_reset();
    chk("R1", "tx_dma_req", tx_dma_req, 1);
    chk("R1", "rx_dma_req", rx_dma_req, 0);
    chk("R1", "irqs", {tx_irq, rx_irq}, 0);
    tx_peek(2'd1, s); chk("R1", "status", s, 0);
    tx_peek(2'd2, s); chk("R1", "tx ctrl", s, 0);
    rx_peek(2'd2, s); chk("R1", "rx ctrl", s, 0);
  endtask

  task automatic t_transfer(logic [7:0] b);
    logic [7:0] s, d;
    tx_write(2'd0, b);
    chk("R2", "full after write", rx_dma_req, 1);
    chk("R10", "tx_dma_req while full", tx_dma_req, 0);
    tx_peek(2'd1, s); chk("R4", "tx status full", s, 8'h01);
    rx_peek(2'd1, s); chk("R4", "rx status full", s, 8'h01);
    rx_pop(d);
    chk("R3", "popped byte", d, b);
    chk("R3", "empty after pop", rx_dma_req, 0);
    chk("R10", "tx_dma_req while empty", tx_dma_req, 1);
  endtask

  task automatic t_overrun();
    logic [7:0] s, d;
    tx_write(2'd0, 8'h3C);
    tx_write(2'd0, 8'hC3);
    tx_peek(2'd1, s); chk("R5", "overrun+full", s, 8'h03);
    rx_pop(d); chk("R5", "first byte kept", d, 8'h3C);
    tx_write(2'd1, 8'h00);
    tx_peek(2'd1, s); chk("R5", "overrun sticky on write 0", s, 8'h02);
    tx_write(2'd1, 8'h02);
    tx_peek(2'd1, s); chk("R5", "overrun cleared", s, 8'h00);
  endtask

  task automatic t_underrun();
    logic [7:0] s, d;
    rx_pop(d); chk("R6", "stale byte", d, 8'h3C);
    chk("R6", "still empty", rx_dma_req, 0);
    rx_peek(2'd1, s); chk("R6", "underrun set", s, 8'h04);
    rx_write(2'd0, 8'h55);
    rx_peek(2'd1, s); chk("R6", "rx data write ignored", s, 8'h04);
    rx_write(2'd1, 8'h04);
    rx_peek(2'd1, s); chk("R6", "underrun cleared", s, 8'h00);
  endtask

  task automatic t_rx_level();
    logic [7:0] d;
    rx_write(2'd2, 8'h01);
    chk("R7", "rx level idle", rx_irq, 0);
    tx_write(2'd0, 8'h11);
    chk("R7", "rx level full", rx_irq, 1);
    @(posedge clk); #1 chk("R7", "rx level holds", rx_irq, 1);
    rx_pop(d);
    chk("R7", "rx level drops", rx_irq, 0);
  endtask

  task automatic t_rx_edge();
    logic [7:0] d;
    rx_write(2'd2, 8'h03);
    tx_write(2'd0, 8'h22);
    chk("R8", "rx pulse", rx_irq, 1);
    @(posedge clk); #1 chk("R8", "rx pulse ends", rx_irq, 0);
    rx_pop(d);
    chk("R8", "rx no pulse on drain", rx_irq, 0);
  endtask

  task automatic t_tx_modes();
    logic [7:0] d;
    tx_write(2'd2, 8'h01);
    chk("R9", "tx level empty", tx_irq, 1);
    tx_write(2'd0, 8'h44);
    chk("R9", "tx level full", tx_irq, 0);
    tx_write(2'd2, 8'h03);
    chk("R9", "tx edge idle", tx_irq, 0);
    rx_pop(d);
    chk("R9", "tx pulse", tx_irq, 1);
    @(posedge clk); #1 chk("R9", "tx pulse ends", tx_irq, 0);
  endtask

  // Same-edge store-while-full and take: take wins, store dropped.
  task automatic t_collision();
    logic [7:0] s;
    tx_write(2'd0, 8'h5A);
    @(negedge clk);
    tx_cs = 1; tx_we = 1; tx_addr = 2'd0; tx_wdata = 8'hA5;
    rx_cs = 1; rx_we = 0; rx_addr = 2'd0;
    #1 chk("R3", "collide pop byte", rx_rdata, 8'h5A);
    @(posedge clk); #1;
    tx_cs = 0; rx_cs = 0;
    chk("R9", "collide tx pulse", tx_irq, 1);
    chk("R8", "collide no rx pulse", rx_irq, 0);
    chk("R5", "collide empty", rx_dma_req, 0);
    @(posedge clk); #1 chk("R9", "collide pulse ends", tx_irq, 0);
    tx_peek(2'd1, s); chk("R5", "collide overrun", s, 8'h02);
    tx_write(2'd1, 8'h02);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    tx_write(2'd2, 8'h02);
    rx_write(2'd2, 8'h00);
    tx_write(2'd0, 8'h77);
    chk("R11", "rx masked full", rx_irq, 0);
    rx_pop(d);
    chk("R11", "tx masked drain", tx_irq, 0);
    tx_write(2'd2, 8'h00);
    chk("R11", "tx masked empty level", tx_irq, 0);
  endtask

  initial begin
    t_reset();
    t_transfer(8'hA5);
    t_transfer(8'h00);
    t_transfer(8'hFF);
    t_overrun();
    t_underrun();
    t_rx_level();
    t_rx_edge();
    t_tx_modes();
    t_collision();
    t_mask();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule